// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block sits between the status side of a UART and the system interrupt line. It holds a four-bit interrupt enable register. It takes the conditions that can raise an interrupt: receiver line errors, received data at the trigger level, a receive character timeout, the transmit holding register going empty, and a modem status change. It ranks the enabled, active conditions and presents the winner as a fixed four-bit identification code. Bits 7:6 of the identification byte carry the FIFO-enabled flags.

The line-error, modem-change and transmitter-empty conditions are held in sticky flags inside the block. Each flag is cleared by its own access pulse from the register decode. The received-data and timeout conditions are levels that the FIFO side drives, so they clear when the FIFO side drops them. The system interrupt output is registered and is gated by the modem-control interrupt-enable bit, which arrives as the input `out2`.

Top module: `uart_irq_ident`

## Requirements
- R1: The enable register resets to 0, loads `ier_wdata` on an `ier_wr` pulse, and reads back on `ier_rdata` from the next cycle. Bit 0 enables receive data and timeout, bit 1 enables transmitter empty, bit 2 enables line status, and bit 3 enables modem status.
- R2: When no enabled source is active, `iir_rdata[3:0]` reads 0x1. Bit 0 set means nothing is pending, and bits 3:1 are zero.
- R3: `iir_rdata[7:6]` reads 2'b11 while `fifo_en` is high and 2'b00 while it is low. Bits 5:4 always read 0.
- R4: Priority runs from highest to lowest as line status (code 0x6), receive data or timeout (0x4 or 0xC), transmitter empty (0x2), then modem status (0x0). Only the highest active enabled source is reported.
- R5: With enable bit 0 set, `rx_ready` high gives code 0x4. `rx_timeout` high with `rx_ready` low gives code 0xC. When both are high, 0x4 is reported. Both conditions follow their inputs with no storage.
- R6: A `line_err` pulse sets the line-status flag, and an `lsr_rd` pulse clears it. Enable bit 2 masks only the reporting, so a flag set while masked appears once the bit is enabled.
- R7: An `msr_chg` pulse sets the modem-status flag, and an `msr_rd` pulse clears it.
- R8: The transmitter-empty flag is set on a rising edge of `thr_empty`. It is also set when enable bit 1 is written from 0 to 1 while `thr_empty` is high. A `thr_wr` pulse clears it.
- R9: An `iir_rd` pulse clears the transmitter-empty flag only when code 0x2 is the value being reported in that cycle. An identification read while a higher source is reported leaves the flag set.
- R10: `irq` is registered. It is high one cycle after `out2` is high and some enabled source is active, and it stays low while `out2` is low.
- R11: When a set event and a clear pulse for the same flag arrive in the same cycle, the set wins and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier_wr | input | 1 | Write strobe for the enable register |
| ier_wdata | input | 4 | Enable register write data |
| ier_rdata | output | 4 | Enable register contents |
| rx_ready | input | 1 | Receive data at or above trigger level (level) |
| rx_timeout | input | 1 | Receive character timeout (level) |
| line_err | input | 1 | Pulse: overrun, parity, framing or break detected |
| lsr_rd | input | 1 | Pulse: line status register read |
| msr_chg | input | 1 | Pulse: modem input changed |
| msr_rd | input | 1 | Pulse: modem status register read |
| thr_empty | input | 1 | Transmit holding register empty (level) |
| thr_wr | input | 1 | Pulse: transmit holding register written |
| iir_rd | input | 1 | Pulse: identification register read |
| fifo_en | input | 1 | FIFOs enabled |
| out2 | input | 1 | Modem-control interrupt output enable |
| iir_rdata | output | 8 | Identification register value |
| irq | output | 1 | System interrupt request |

## Verification
The bench builds the block with its defaults: the timeout code is enabled and the interrupt output is registered. This configuration exposes the distinct 0xC code next to 0x4 and the one-cycle latency of `irq` behind the identification value. Because the latency is fixed at one cycle, the check can pin the exact cycle in which the gate takes effect. The mask-then-enable sequence and the same-cycle set/clear collisions only appear with the sticky flags and the registered output in place.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int unsigned EN_W  = 4;
   localparam int unsigned SRC_N = 4;
   localparam int unsigned ID_W  = 4;

   // Enable register bit positions
   localparam int unsigned EN_RX    = 0;
   localparam int unsigned EN_THR   = 1;
   localparam int unsigned EN_LINE  = 2;
   localparam int unsigned EN_MODEM = 3;

   // Source rank, index 0 is the highest priority
   localparam int unsigned RK_LINE  = 0;
   localparam int unsigned RK_RX    = 1;
   localparam int unsigned RK_THR   = 2;
   localparam int unsigned RK_MODEM = 3;

   typedef enum logic [ID_W-1:0] {
      ID_MODEM   = 4'h0,
      ID_NONE    = 4'h1,
      ID_THR     = 4'h2,
      ID_RXDATA  = 4'h4,
      ID_LINE    = 4'h6,
      ID_TIMEOUT = 4'hC
   } irq_id_e;
endpackage

// File: rtl/uart_irq_enable_reg.sv
module uart_irq_enable_reg
   import uart_irq_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [EN_W-1:0] wdata,
   output logic [EN_W-1:0] en,
   output logic            thr_en_rise
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en <= '0;
      else if (wr) en <= wdata;
   end

   assign thr_en_rise = wr && wdata[EN_THR] && !en[EN_THR];

   AST_IER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> en == $past(wdata)); // R1
endmodule

// File: rtl/uart_irq_pending.sv
module uart_irq_pending
   import uart_irq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic line_err,
   input  logic lsr_rd,
   input  logic msr_chg,
   input  logic msr_rd,
   input  logic thr_empty,
   input  logic thr_wr,
   input  logic thr_en_rise,
   input  logic iir_rd_thr,
   output logic line_pend,
   output logic modem_pend,
   output logic thr_pend
);
   localparam int unsigned STICKY_N = 2;

   logic [STICKY_N-1:0] st_set, st_clr, st_q;
   assign st_set = {msr_chg, line_err};
   assign st_clr = {msr_rd,  lsr_rd};

   for (genvar g = 0; g < STICKY_N; g++) begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         st_q[g] <= 1'b0;
         else if (st_set[g]) st_q[g] <= 1'b1;
         else if (st_clr[g]) st_q[g] <= 1'b0;
      end
   end

   assign line_pend  = st_q[0];
   assign modem_pend = st_q[1];

   logic thr_q;
   logic thr_set;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) thr_q <= 1'b1;
      else        thr_q <= thr_empty;
   end

   assign thr_set = thr_empty && (!thr_q || thr_en_rise);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    thr_pend <= 1'b0;
      else if (thr_set)              thr_pend <= 1'b1;
      else if (thr_wr || iir_rd_thr) thr_pend <= 1'b0;
   end

   AST_LSR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && !line_err) |=> !line_pend); // R6
   AST_MSR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (msr_rd && !msr_chg) |=> !modem_pend); // R7
   AST_THR_WR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_wr && !thr_empty) |=> !thr_pend); // R8
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      line_err |=> line_pend); // R11
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
#(
   parameter bit TIMEOUT_EN = 1'b1
) (
   input  logic [SRC_N-1:0] act,
   input  logic             rx_by_tmo,
   output irq_id_e          id,
   output logic             any
);
   function automatic irq_id_e code_of(int unsigned rank, logic tmo);
      case (rank)
         RK_LINE:  return ID_LINE;
         RK_RX:    return (TIMEOUT_EN && tmo) ? ID_TIMEOUT : ID_RXDATA;
         RK_THR:   return ID_THR;
         default:  return ID_MODEM;
      endcase
   endfunction

   always_comb begin
      any = 1'b0;
      id  = ID_NONE;
      for (int i = SRC_N - 1; i >= 0; i--) begin
         if (act[i]) begin
            any = 1'b1;
            id  = code_of(i, rx_by_tmo);
         end
      end
   end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter bit TIMEOUT_EN = 1'b1,
   parameter bit REG_IRQ    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ier_wr,
   input  logic [3:0] ier_wdata,
   output logic [3:0] ier_rdata,
   input  logic       rx_ready,
   input  logic       rx_timeout,
   input  logic       line_err,
   input  logic       lsr_rd,
   input  logic       msr_chg,
   input  logic       msr_rd,
   input  logic       thr_empty,
   input  logic       thr_wr,
   input  logic       iir_rd,
   input  logic       fifo_en,
   input  logic       out2,
   output logic [7:0] iir_rdata,
   output logic       irq
);
   localparam int unsigned FLAG_W = 2;

   if (EN_W != 4) begin : g_bad_en_w
      $error("enable register must be four bits wide");
   end
   if (SRC_N != 4) begin : g_bad_src_n
      $error("priority encoder expects four ranked sources");
   end

   logic [EN_W-1:0]  en;
   logic             thr_en_rise;
   logic             line_pend, modem_pend, thr_pend;
   logic [SRC_N-1:0] act;
   logic             rx_src, rx_by_tmo;
   irq_id_e          id;
   logic             any;
   logic             iir_rd_thr;

   uart_irq_enable_reg u_en (
      .clk(clk), .rst_n(rst_n), .wr(ier_wr), .wdata(ier_wdata),
      .en(en), .thr_en_rise(thr_en_rise)
   );

   uart_irq_pending u_pend (
      .clk(clk), .rst_n(rst_n),
      .line_err(line_err), .lsr_rd(lsr_rd),
      .msr_chg(msr_chg), .msr_rd(msr_rd),
      .thr_empty(thr_empty), .thr_wr(thr_wr),
      .thr_en_rise(thr_en_rise), .iir_rd_thr(iir_rd_thr),
      .line_pend(line_pend), .modem_pend(modem_pend), .thr_pend(thr_pend)
   );

   if (TIMEOUT_EN) begin : g_tmo
      assign rx_src    = rx_ready || rx_timeout;
      assign rx_by_tmo = !rx_ready;
   end else begin : g_no_tmo
      assign rx_src    = rx_ready;
      assign rx_by_tmo = 1'b0;
   end

   always_comb begin
      act           = '0;
      act[RK_LINE]  = line_pend  && en[EN_LINE];
      act[RK_RX]    = rx_src     && en[EN_RX];
      act[RK_THR]   = thr_pend   && en[EN_THR];
      act[RK_MODEM] = modem_pend && en[EN_MODEM];
   end

   uart_irq_prio #(.TIMEOUT_EN(TIMEOUT_EN)) u_prio (
      .act(act), .rx_by_tmo(rx_by_tmo), .id(id), .any(any)
   );

   assign iir_rd_thr = iir_rd && (id == ID_THR);
   assign iir_rdata  = {{FLAG_W{fifo_en}}, 2'b00, id};
   assign ier_rdata  = en;

   if (REG_IRQ) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= out2 && any;
      end
      assign irq = irq_q;

      AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
         !out2 |=> !irq); // R10
   end else begin : g_irq_comb
      assign irq = out2 && any;
   end

   AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      iir_rdata[0] |-> (iir_rdata[3:1] == 3'b000)); // R2
   AST_FIFO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      iir_rdata[7:4] == {fifo_en, fifo_en, 2'b00}); // R3
   AST_LINE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (line_pend && en[EN_LINE]) |-> (iir_rdata[3:0] == 4'h6)); // R4
   AST_THR_READ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (iir_rd && thr_pend && (iir_rdata[3:0] != 4'h2) && !thr_wr) |=> thr_pend); // R9
endmodule

// File: tb/uart_irq_ident_tb_top.sv
module uart_irq_ident_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 8;
   // {ier[3:0], fifo_en, rx_ready, rx_timeout, expected iir[7:0]}
   localparam logic [14:0] VEC [NVEC] = '{
      {4'h0, 1'b0, 1'b1, 1'b0, 8'h01},
      {4'h1, 1'b0, 1'b1, 1'b0, 8'h04},
      {4'h1, 1'b1, 1'b1, 1'b0, 8'hC4},
      {4'h1, 1'b1, 1'b0, 1'b1, 8'hCC},
      {4'h1, 1'b0, 1'b1, 1'b1, 8'h04},
      {4'h1, 1'b1, 1'b0, 1'b0, 8'hC1},
      {4'hE, 1'b0, 1'b1, 1'b1, 8'h01},
      {4'hF, 1'b0, 1'b0, 1'b1, 8'h0C}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ier_wr = 0, rx_ready = 0, rx_timeout = 0, line_err = 0, lsr_rd = 0;
   logic msr_chg = 0, msr_rd = 0, thr_empty = 0, thr_wr = 0, iir_rd = 0;
   logic fifo_en = 0, out2 = 1;
   logic [3:0] ier_wdata = '0;
   logic [3:0] ier_rdata;
   logic [7:0] iir_rdata;
   logic       irq;
   int n_chk = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_irq_ident dut_i (
      .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
      .ier_rdata(ier_rdata), .rx_ready(rx_ready), .rx_timeout(rx_timeout),
      .line_err(line_err), .lsr_rd(lsr_rd), .msr_chg(msr_chg), .msr_rd(msr_rd),
      .thr_empty(thr_empty), .thr_wr(thr_wr), .iir_rd(iir_rd),
      .fifo_en(fifo_en), .out2(out2), .iir_rdata(iir_rdata), .irq(irq)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
      end
   endtask

   task automatic wr_ier(input logic [3:0] v);
      ier_wr = 1; ier_wdata = v;
      tick();
      ier_wr = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      rst_n = 1;
      // Reset state: R1, R2, R10
      chk("R1 reset enable", {4'h0, ier_rdata}, 8'h00);
      chk("R2 reset ident", iir_rdata, 8'h01);
      chk("R10 reset irq", {7'h0, irq}, 8'h00);

      wr_ier(4'hA);
      chk("R1 readback", {4'h0, ier_rdata}, 8'h0A);

      // Table walk over level sources: R5, R3, R2, R10
      for (int i = 0; i < NVEC; i++) begin
         ier_wr = 1; ier_wdata = VEC[i][14:11];
         fifo_en = VEC[i][10]; rx_ready = VEC[i][9]; rx_timeout = VEC[i][8];
         tick();
         ier_wr = 0;
         chk($sformatf("R5 vector %0d ident", i), iir_rdata, VEC[i][7:0]);
         tick();
         chk($sformatf("R10 vector %0d irq", i), {7'h0, irq}, {7'h0, ~VEC[i][0]});
      end
      rx_ready = 0; rx_timeout = 0; fifo_en = 0;

      // R6: masked flag appears on enable, cleared by status read
      wr_ier(4'h0);
      line_err = 1; tick(); line_err = 0;
      chk("R6 masked", iir_rdata, 8'h01);
      wr_ier(4'h4);
      chk("R6 unmasked", iir_rdata, 8'h06);
      lsr_rd = 1; tick(); lsr_rd = 0;
      chk("R6 cleared", iir_rdata, 8'h01);

      // R7: modem flag
      wr_ier(4'h8);
      msr_chg = 1; tick(); msr_chg = 0;
      chk("R7 set", iir_rdata, 8'h00);
      tick();
      chk("R10 modem irq", {7'h0, irq}, 8'h01);
      msr_rd = 1; tick(); msr_rd = 0;
      chk("R7 cleared", iir_rdata, 8'h01);

      // R4: all sources, peel from the top
      wr_ier(4'hF);
      line_err = 1; msr_chg = 1; rx_ready = 1; thr_empty = 1;
      tick();
      line_err = 0; msr_chg = 0;
      chk("R4 line first", iir_rdata, 8'h06);
      lsr_rd = 1; tick(); lsr_rd = 0;
      chk("R4 data second", iir_rdata, 8'h04);
      rx_ready = 0; tick();
      chk("R4 thr third", iir_rdata, 8'h02);
      iir_rd = 1; tick(); iir_rd = 0;
      chk("R9 read clears thr", iir_rdata, 8'h00);
      msr_rd = 1; tick(); msr_rd = 0;
      chk("R4 modem last", iir_rdata, 8'h01);

      // R9: ident read while line reported keeps thr
      thr_empty = 0; tick();
      thr_empty = 1; line_err = 1; tick(); line_err = 0;
      chk("R9 line over thr", iir_rdata, 8'h06);
      iir_rd = 1; tick(); iir_rd = 0;
      lsr_rd = 1; tick(); lsr_rd = 0;
      chk("R9 thr kept", iir_rdata, 8'h02);

      // R8: write clears; enable rise while empty sets
      thr_wr = 1; tick(); thr_wr = 0;
      chk("R8 write clears", iir_rdata, 8'h01);
      wr_ier(4'h0);
      wr_ier(4'h2);
      chk("R8 enable rise sets", iir_rdata, 8'h02);
      thr_wr = 1; tick(); thr_wr = 0;
      chk("R8 cleared again", iir_rdata, 8'h01);

      // R11: set and clear in the same cycle
      wr_ier(4'h4);
      line_err = 1; lsr_rd = 1; tick(); line_err = 0; lsr_rd = 0;
      chk("R11 set wins", iir_rdata, 8'h06);

      // R10: gate by out2
      out2 = 0; tick(); tick();
      chk("R10 gated low", {7'h0, irq}, 8'h00);
      out2 = 1; tick();
      chk("R10 ungated", {7'h0, irq}, 8'h01);
      lsr_rd = 1; tick(); lsr_rd = 0;
      tick();
      chk("R10 drops", {7'h0, irq}, 8'h00);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule